// File: doc/BRIEF.md
# TDM Network-Mode Serial Receiver

This block is the receive half of a synchronous serial port that carries time-division-multiplexed frames. An external bit clock runs without pause. A frame sync pulse marks where a frame starts, and each frame holds `SLOTS` time slots of `WORD_W` bits each. The serial data pin is sampled on every falling bit-clock edge. The block keeps no list of wanted slots: it assembles a word in every slot and hands each one over in order. A flag marks the word that came from the first slot of the frame, so software can tell which slot each word belongs to and drop the ones it does not need.

The serial inputs are oversampled by the system clock. Completed words go into a receive queue. With the queue option off, the queue holds a single entry and acts as a plain receive data register. With the option on, it holds up to `DEPTH` entries and the ready flag follows a programmable fill threshold. Software takes the head word by pulsing a read acknowledge. Configuration inputs select the sync polarity, single-bit or whole-word sync, and whether the sync comes during the first data bit or one bit before it. After the enable is raised, reception waits for the next frame sync.

Top module: `tdm_rx`

## Requirements
- R1: After a synchronous reset the level output is 0, and ready, interrupt and overrun are all 0.
- R2: The data pin is sampled on each falling edge of the bit clock. The first sampled bit of a slot becomes the most significant bit of its `WORD_W`-bit word.
- R3: Every slot of a frame produces one word, and words reach the output in arrival order. The slot counter runs from 0 to `SLOTS`-1 and then wraps to 0.
- R4: After the enable rises, no word is assembled until a frame sync is recognised. While the enable is low, no new words enter the queue.
- R5: `rx_slot0_o` is 1 exactly when the head word was received in slot 0.
- R6: With the queue option off, ready is 1 while an unread word is held, and a read acknowledge clears it. If a read and a new word fall in the same cycle, the new word replaces the old one, ready stays 1 and no overrun is flagged.
- R7: With the queue option on, up to `DEPTH` words are held, and ready is 1 while the level is at least the watermark. A watermark of 0 acts as 1.
- R8: A word that completes while the queue is full (1 entry with the option off, `DEPTH` with it on) and no read happens in that cycle is dropped. The held data is kept, and overrun is set until the next read.
- R9: With early timing selected, the sync is recognised on the bit before the first data bit. With standard timing, it is recognised on the first data bit itself.
- R10: With polarity inversion selected, a low level on the frame sync pin counts as active.
- R11: With single-bit sync, an active level at a sample is recognised as a sync. With word-long sync, only the sample where the level turns active is recognised.
- R12: The interrupt is 1 exactly when ready is 1 and the interrupt enable is set.
- R13: A sync recognised in the middle of a frame restarts counting at bit 0 of slot 0. The partly assembled word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock, oversampled |
| fs_i | input | 1 | Frame sync pin |
| sd_i | input | 1 | Serial data pin |
| cfg_en_i | input | 1 | Receiver enable |
| cfg_fifo_en_i | input | 1 | Queue option: 1 gives `DEPTH` entries, 0 gives one entry |
| cfg_wm_i | input | $clog2(DEPTH)+1 | Ready watermark when the queue option is on |
| cfg_fs_inv_i | input | 1 | 1: frame sync is active low |
| cfg_fs_word_i | input | 1 | 1: word-long sync (leading edge), 0: single-bit sync (level) |
| cfg_fs_early_i | input | 1 | 1: sync comes one bit before the first data bit |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| rd_ack_i | input | 1 | Read acknowledge, takes the head word |
| rx_data_o | output | WORD_W | Head word |
| rx_slot0_o | output | 1 | Head word came from slot 0 |
| rx_rdy_o | output | 1 | Data-ready flag |
| rx_irq_o | output | 1 | Receive interrupt |
| rx_ovr_o | output | 1 | Overrun flag |
| rx_level_o | output | $clog2(DEPTH)+1 | Number of words held |

## Verification
The tricky overlap is a read acknowledge that lands on the same system-clock edge as a newly completed word. This matters most when the single-entry register is full, because in that cycle the pop must make room for the incoming word. The bench provokes this with a reader that waits until its reference model shows a word due on the next edge, and only then pulses the acknowledge. The outcome is judged on every cycle against the model: level, ready and head data must match, overrun must stay clear, and all five slot words must come out in order. A second overlap, a full queue that drops a word while nothing is read, is provoked by leaving the reader idle. There the check is that the head data and the level stay unchanged while overrun rises.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

  // Frame sync interpretation, shared by the sampler and the top level
  typedef struct packed {
    logic inv;       // active-low sync pin
    logic word_len;  // sync spans a word: react to its leading edge only
    logic early;     // sync precedes the first data bit by one bit
  } fs_cfg_t;

endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge
  import tdm_rx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bclk_i,
  input  logic    fs_i,
  input  logic    sd_i,
  input  fs_cfg_t cfg,
  output logic    smp_v_o,
  output logic    smp_d_o,
  output logic    smp_start_o
);

  logic bclk_q, bclk_qq, fs_q, sd_q;
  logic fs_prev, early_pend;
  logic fall, fs_act, sync_hit;

  assign fall     = bclk_qq & ~bclk_q;
  assign fs_act   = fs_q ^ cfg.inv;
  assign sync_hit = cfg.word_len ? (fs_act & ~fs_prev) : fs_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q      <= 1'b0;
      bclk_qq     <= 1'b0;
      fs_q        <= 1'b0;
      sd_q        <= 1'b0;
      fs_prev     <= 1'b0;
      early_pend  <= 1'b0;
      smp_v_o     <= 1'b0;
      smp_d_o     <= 1'b0;
      smp_start_o <= 1'b0;
    end else begin
      bclk_q  <= bclk_i;
      bclk_qq <= bclk_q;
      fs_q    <= fs_i;
      sd_q    <= sd_i;
      smp_v_o <= fall;
      if (fall) begin
        fs_prev     <= fs_act;
        early_pend  <= cfg.early & sync_hit;
        smp_d_o     <= sd_q;
        smp_start_o <= cfg.early ? early_pend : sync_hit;
      end
    end
  end

endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int WORD_W = 8,
  parameter int SLOTS  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              smp_v_i,
  input  logic              d_i,
  input  logic              start_i,
  output logic              word_v_o,
  output logic [WORD_W-1:0] word_o,
  output logic              slot0_o
);

  localparam int BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [BW-1:0]     bit_idx, idx_now;
  logic [SW-1:0]     slot_idx, slot_now;
  logic              active, go;
  logic [WORD_W-2:0] sh;
  logic [WORD_W-1:0] sh_next;

  assign go       = en_i & (start_i | active);
  assign idx_now  = start_i ? '0 : bit_idx;
  assign slot_now = start_i ? '0 : slot_idx;
  assign sh_next  = {sh, d_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx  <= '0;
      slot_idx <= '0;
      active   <= 1'b0;
      sh       <= '0;
      word_v_o <= 1'b0;
      word_o   <= '0;
      slot0_o  <= 1'b0;
    end else begin
      word_v_o <= 1'b0;
      if (!en_i) begin
        active <= 1'b0;
      end else if (smp_v_i && go) begin
        active <= 1'b1;
        sh     <= sh_next[WORD_W-2:0];
        if (idx_now == BW'(WORD_W-1)) begin
          word_v_o <= 1'b1;
          word_o   <= sh_next;
          slot0_o  <= (slot_now == '0);
          bit_idx  <= '0;
          slot_idx <= (slot_now == SW'(SLOTS-1)) ? '0 : slot_now + 1'b1;
        end else begin
          bit_idx  <= idx_now + 1'b1;
          slot_idx <= slot_now;
        end
      end
    end
  end

endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en_i,
  input  logic [CW-1:0]     wm_i,
  input  logic              irq_en_i,
  input  logic              wr_v_i,
  input  logic [WORD_W-1:0] wr_d_i,
  input  logic              wr_s0_i,
  input  logic              rd_ack_i,
  output logic [WORD_W-1:0] data_o,
  output logic              slot0_o,
  output logic              rdy_o,
  output logic              irq_o,
  output logic              ovr_o,
  output logic [CW-1:0]     level_o
);

  // Storage has no reset so it can map onto RAM resources
  logic [WORD_W:0] mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt, cnt_nx, cap, thr;
  logic            full, pop, push, drop, rdy_nx;

  assign cap    = fifo_en_i ? CW'(DEPTH) : CW'(1);
  assign thr    = (!fifo_en_i || wm_i == '0) ? CW'(1) : wm_i;
  assign full   = cnt >= cap;
  assign pop    = rd_ack_i && (cnt != '0);
  assign push   = wr_v_i && (!full || pop);
  assign drop   = wr_v_i && full && !pop;
  assign rdy_nx = cnt_nx >= thr;

  always_comb begin
    case ({push, pop})
      2'b10:   cnt_nx = cnt + 1'b1;
      2'b01:   cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {wr_s0_i, wr_d_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      rdy_o <= 1'b0;
      irq_o <= 1'b0;
      ovr_o <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      rdy_o <= rdy_nx;
      irq_o <= rdy_nx & irq_en_i;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (drop)     ovr_o <= 1'b1;
      else if (pop) ovr_o <= 1'b0;
    end
  end

  assign {slot0_o, data_o} = mem[rp];
  assign level_o = cnt;

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SLOTS  = 5,
  parameter int DEPTH  = 4,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_i,
  input  logic              fs_i,
  input  logic              sd_i,
  input  logic              cfg_en_i,
  input  logic              cfg_fifo_en_i,
  input  logic [LW-1:0]     cfg_wm_i,
  input  logic              cfg_fs_inv_i,
  input  logic              cfg_fs_word_i,
  input  logic              cfg_fs_early_i,
  input  logic              cfg_irq_en_i,
  input  logic              rd_ack_i,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              rx_slot0_o,
  output logic              rx_rdy_o,
  output logic              rx_irq_o,
  output logic              rx_ovr_o,
  output logic [LW-1:0]     rx_level_o
);

  fs_cfg_t           fs_cfg;
  logic              smp_v, smp_d, smp_start;
  logic              word_v, word_s0;
  logic [WORD_W-1:0] word_d;

  assign fs_cfg = '{inv: cfg_fs_inv_i, word_len: cfg_fs_word_i, early: cfg_fs_early_i};

  tdm_rx_edge u_edge (
    .clk         (clk),
    .rst         (rst),
    .bclk_i      (bclk_i),
    .fs_i        (fs_i),
    .sd_i        (sd_i),
    .cfg         (fs_cfg),
    .smp_v_o     (smp_v),
    .smp_d_o     (smp_d),
    .smp_start_o (smp_start)
  );

  tdm_rx_deser #(.WORD_W(WORD_W), .SLOTS(SLOTS)) u_deser (
    .clk      (clk),
    .rst      (rst),
    .en_i     (cfg_en_i),
    .smp_v_i  (smp_v),
    .d_i      (smp_d),
    .start_i  (smp_start),
    .word_v_o (word_v),
    .word_o   (word_d),
    .slot0_o  (word_s0)
  );

  tdm_rx_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .fifo_en_i (cfg_fifo_en_i),
    .wm_i      (cfg_wm_i),
    .irq_en_i  (cfg_irq_en_i),
    .wr_v_i    (word_v),
    .wr_d_i    (word_d),
    .wr_s0_i   (word_s0),
    .rd_ack_i  (rd_ack_i),
    .data_o    (rx_data_o),
    .slot0_o   (rx_slot0_o),
    .rdy_o     (rx_rdy_o),
    .irq_o     (rx_irq_o),
    .ovr_o     (rx_ovr_o),
    .level_o   (rx_level_o)
  );

endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 4,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_en_i,
  input logic              cfg_irq_en_i,
  input logic [WORD_W-1:0] rx_data_o,
  input logic              rx_rdy_o,
  input logic              rx_irq_o,
  input logic              rx_ovr_o,
  input logic [LW-1:0]     rx_level_o
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_level_o <= LW'(DEPTH)); // R7

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (rx_level_o == $past(rx_level_o)) ||
             (rx_level_o == $past(rx_level_o) + 1'b1) ||
             (rx_level_o + 1'b1 == $past(rx_level_o))); // R7

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ovr_o) |-> $stable(rx_data_o) && $stable(rx_level_o)); // R8

  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (rx_level_o == '0) |-> !rx_rdy_o); // R6

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_irq_en_i) |-> !rx_irq_o); // R12

  AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!$past(cfg_en_i) && !$past(cfg_en_i, 2)) |-> rx_level_o <= $past(rx_level_o)); // R4

endmodule

bind tdm_rx tdm_rx_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_en_i     (cfg_en_i),
  .cfg_irq_en_i (cfg_irq_en_i),
  .rx_data_o    (rx_data_o),
  .rx_rdy_o     (rx_rdy_o),
  .rx_irq_o     (rx_irq_o),
  .rx_ovr_o     (rx_ovr_o),
  .rx_level_o   (rx_level_o)
);

// File: tb/tdm_rx_tb.sv
module tdm_rx_tb;
  localparam int CLK_P = 10;
  localparam int W  = 8;
  localparam int S  = 5;
  localparam int D  = 4;
  localparam int LW = $clog2(D) + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic bclk = 1'b0, fs = 1'b0, sd = 1'b0;
  logic en = 1'b0, fen = 1'b0, inv = 1'b0, wlen = 1'b0, early = 1'b0, ien = 1'b0, rd = 1'b0;
  logic [LW-1:0] wm = 1;
  logic [W-1:0]  rx_data;
  logic          rx_slot0, rx_rdy, rx_irq, rx_ovr;
  logic [LW-1:0] rx_level;

  always #(CLK_P/2) clk = ~clk;

  tdm_rx #(.WORD_W(W), .SLOTS(S), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst), .bclk_i(bclk), .fs_i(fs), .sd_i(sd),
    .cfg_en_i(en), .cfg_fifo_en_i(fen), .cfg_wm_i(wm), .cfg_fs_inv_i(inv),
    .cfg_fs_word_i(wlen), .cfg_fs_early_i(early), .cfg_irq_en_i(ien), .rd_ack_i(rd),
    .rx_data_o(rx_data), .rx_slot0_o(rx_slot0), .rx_rdy_o(rx_rdy), .rx_irq_o(rx_irq),
    .rx_ovr_o(rx_ovr), .rx_level_o(rx_level)
  );

  typedef struct { int due; logic [W-1:0] d; bit s0; } pend_t;
  typedef struct { logic [W-1:0] d; bit s0; } word_t;

  int checks = 0, fails = 0, cyc = 0, rmode = 0;
  pend_t pq[$];
  word_t mq[$], got[$], exp_q[$];
  bit bq[$], fq[$];
  bit m_ovr = 0, m_rdy = 0, m_irq = 0;
  bit m_fprev = 0, m_pend = 0, m_act = 0;
  int m_idx = 0, m_slot = 0;
  logic [W-1:0] m_sh = '0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Reference model of the queue, advanced on every rising clock edge
  always @(posedge clk) begin : model
    bit popv, full;
    int cap, thr;
    word_t w;
    cyc++;
    if (rst) begin
      mq.delete(); pq.delete();
      m_ovr = 0; m_rdy = 0; m_irq = 0;
      m_fprev = 0; m_pend = 0; m_act = 0; m_idx = 0; m_slot = 0;
    end else begin
      cap  = fen ? D : 1;
      thr  = (!fen || wm == 0) ? 1 : int'(wm);
      full = mq.size() >= cap;
      popv = rd && mq.size() > 0;
      if (popv) begin
        void'(mq.pop_front());
        m_ovr = 0;
      end
      if (pq.size() > 0 && pq[0].due == cyc) begin
        w.d  = pq[0].d;
        w.s0 = pq[0].s0;
        void'(pq.pop_front());
        if (!full || popv) mq.push_back(w);
        else m_ovr = 1;
      end
      m_rdy = mq.size() >= thr;
      m_irq = m_rdy && ien;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      chk(int'(rx_level) == mq.size(), "R7", "level", int'(rx_level), mq.size());
      chk(rx_rdy == m_rdy, "R6", "ready", rx_rdy, m_rdy);
      chk(rx_irq == m_irq, "R12", "irq", rx_irq, m_irq);
      chk(rx_ovr == m_ovr, "R8", "overrun", rx_ovr, m_ovr);
      if (mq.size() > 0) begin
        chk(rx_data == mq[0].d, "R3", "head data", int'(rx_data), int'(mq[0].d));
        chk(rx_slot0 == mq[0].s0, "R5", "slot0 flag", rx_slot0, mq[0].s0);
      end
    end
  end

  // Reader: 1 drains whenever words are held, 2 reads only on the edge a new word lands
  always @(negedge clk) begin
    bit go;
    go = 0;
    if (!rst && rx_level != 0) begin
      if (rmode == 1) go = 1;
      if (rmode == 2 && pq.size() > 0 && pq[0].due == cyc + 1) go = 1;
    end
    if (go) got.push_back('{rx_data, rx_slot0});
    rd = go;
  end

  task automatic model_fall(bit d, bit f);
    bit hit, st;
    hit = wlen ? (f && !m_fprev) : f;
    m_fprev = f;
    st = early ? m_pend : hit;
    m_pend = early && hit;
    if (!en) m_act = 0;
    else if (st || m_act) begin
      if (st) begin m_idx = 0; m_slot = 0; end
      m_act = 1;
      m_sh = {m_sh[W-2:0], d};
      if (m_idx == W-1) begin
        pq.push_back('{cyc + 4, m_sh, (m_slot == 0)});
        m_idx = 0;
        m_slot = (m_slot == S-1) ? 0 : m_slot + 1;
      end else m_idx++;
    end
  endtask

  task automatic drive_bit(bit d, bit f);
    @(negedge clk);
    bclk = 1'b1; sd = d; fs = f ^ inv;
    repeat (2) @(negedge clk);
    bclk = 1'b0;
    model_fall(d, f);
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] wval(int base, int s);
    return W'(base + s * 37);
  endfunction

  task automatic add_bits(logic [W-1:0] w, int n, bit sync);
    for (int b = 0; b < n; b++) begin
      bq.push_back(w[W-1-b]);
      fq.push_back(sync && !early && (wlen || b == 0));
    end
  endtask

  task automatic add_frame(int base);
    if (early) begin
      if (bq.size() == 0) begin bq.push_back(0); fq.push_back(0); end
      fq[fq.size()-1] = 1;
    end
    for (int s = 0; s < S; s++) add_bits(wval(base, s), W, s == 0);
  endtask

  task automatic expect_frame(int base);
    for (int s = 0; s < S; s++) exp_q.push_back('{wval(base, s), (s == 0)});
  endtask

  task automatic play_n(int n);
    for (int i = 0; i < n && bq.size() > 0; i++) begin
      drive_bit(bq[0], fq[0]);
      void'(bq.pop_front());
      void'(fq.pop_front());
    end
  endtask

  task automatic settle();
    repeat (14) @(negedge clk);
  endtask

  task automatic compare_got(string tag);
    chk(got.size() == exp_q.size(), tag, "word count", got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++) begin
      chk(got[i].d == exp_q[i].d, tag, "word value", int'(got[i].d), int'(exp_q[i].d));
      chk(got[i].s0 == exp_q[i].s0, tag, "slot0 tag", got[i].s0, exp_q[i].s0);
    end
    got.delete();
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rx_level == 0, "R1", "level after reset", int'(rx_level), 0);
    chk(rx_rdy == 0, "R1", "ready after reset", rx_rdy, 0);
    chk(rx_irq == 0, "R1", "irq after reset", rx_irq, 0);
    chk(rx_ovr == 0, "R1", "overrun after reset", rx_ovr, 0);

    // R2 R3 R5 R6: two frames, single register, drained as words land
    en = 1; fen = 0; rmode = 1; ien = 1;
    add_frame(8'h11); add_frame(8'hA5);
    expect_frame(8'h11); expect_frame(8'hA5);
    play_n(bq.size()); settle();
    compare_got("R2");

    // R4: enable raised mid-frame waits for the next sync, then disable blocks words
    en = 0;
    add_frame(8'h30); add_frame(8'h4C);
    play_n(20); en = 1; play_n(bq.size()); settle();
    expect_frame(8'h4C);
    compare_got("R4");
    en = 0;
    add_frame(8'h52); play_n(bq.size()); settle();
    compare_got("R4");
    en = 1;

    // R7 R8 R12: queue on, no reader, watermark 3, five words into four places
    fen = 1; wm = 3; rmode = 0;
    add_frame(8'h63); play_n(bq.size()); settle();
    chk(rx_level == D, "R7", "queue level", int'(rx_level), D);
    chk(rx_rdy == 1, "R7", "ready at watermark", rx_rdy, 1);
    chk(rx_ovr == 1, "R8", "overrun on full queue", rx_ovr, 1);
    chk(rx_irq == 1, "R12", "irq with enable", rx_irq, 1);
    ien = 0; @(negedge clk);
    chk(rx_irq == 0, "R12", "irq masked", rx_irq, 0);
    rmode = 1; settle();
    for (int s = 0; s < D; s++) exp_q.push_back('{wval(8'h63, s), (s == 0)});
    compare_got("R8");
    chk(rx_ovr == 0, "R8", "overrun cleared by read", rx_ovr, 0);

    // R8: single register keeps its first word when nobody reads
    fen = 0; rmode = 0; ien = 1;
    add_frame(8'h71); play_n(bq.size()); settle();
    chk(rx_level == 1, "R8", "register level", int'(rx_level), 1);
    chk(rx_data == wval(8'h71, 0), "R8", "old data kept", int'(rx_data), int'(wval(8'h71, 0)));
    chk(rx_ovr == 1, "R8", "overrun set", rx_ovr, 1);
    rmode = 1; settle();
    exp_q.push_back('{wval(8'h71, 0), 1'b1});
    compare_got("R8");

    // R6: read and new word on the same edge
    rmode = 2;
    add_frame(8'h85); play_n(bq.size()); settle();
    rmode = 1; settle();
    chk(rx_ovr == 0, "R6", "no overrun on same-cycle read", rx_ovr, 0);
    expect_frame(8'h85);
    compare_got("R6");

    // R9 with R7 watermark 0: early sync timing
    fen = 1; wm = 0; early = 1;
    add_frame(8'h91); add_frame(8'h13); play_n(bq.size()); settle();
    expect_frame(8'h91); expect_frame(8'h13);
    compare_got("R9");
    early = 0;

    // R10: inverted sync polarity
    inv = 1; fs = 1;
    add_frame(8'h27); add_frame(8'hC2); play_n(bq.size()); settle();
    expect_frame(8'h27); expect_frame(8'hC2);
    compare_got("R10");
    inv = 0; fs = 0;

    // R11: word-long sync reacts to its leading edge only
    wlen = 1;
    add_frame(8'h3B); add_frame(8'hE4); play_n(bq.size()); settle();
    expect_frame(8'h3B); expect_frame(8'hE4);
    compare_got("R11");
    wlen = 0;

    // R13: sync in the middle of a frame restarts slot counting
    add_bits(8'hD1, W, 1); add_bits(8'h5E, W, 0); add_bits(8'hFF, 3, 0);
    add_frame(8'h0F);
    play_n(bq.size()); settle();
    exp_q.push_back('{8'hD1, 1'b1}); exp_q.push_back('{8'h5E, 1'b0});
    expect_frame(8'h0F);
    compare_got("R13");

    report();
  end

endmodule